// File: doc/BRIEF.md
# Memory-Mapped Flash Read Window Engine

This block turns reads of a memory-mapped window into complete serial-flash read operations. Software first loads an operation word (read flag, address byte count, dummy cycle count, double-rate data flag), a flash base address, a window length, and a control word that carries the opcode, the target chip select and an enable bit. Once the engine is enabled, each window read with an in-range offset selects one flash device, sends the opcode and the address `base + offset` on a single data line, inserts the dummy clocks, reads one data byte and returns it on a ready/valid response channel.

Reads that cannot be served get an error response in the next cycle and never touch the flash. These are reads outside the window, reads while the engine is disabled, and reads while the read flag is clear. Clearing the enable bit stops the engine in an orderly way. A read already in flight finishes and hands over its response first. After that the engine is idle, chip select is released, and a sticky status bit reports that it has stopped. Software clears this bit by writing a one to it.

Top module: `linrd_engine`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, no response is pending, the stopped status is 0 and the request channel is ready.
- R2: An accepted read sends the opcode (control bits [7:0]) and then A address bytes of `base + offset` (truncated to A bytes), both most significant bit first. A comes from operation-word bits [16:14], and a value above 4 counts as 4. The serial clock idles low, and the data line changes only while the clock is low.
- R3: After the address, the engine gives the number of serial-clock cycles in operation-word bits [22:17] as dummy cycles, with the data line held low.
- R4: When operation-word bit 8 is clear, the data byte takes 8 serial-clock cycles and is sampled most significant bit first, just before each rising edge.
- R5: When operation-word bit 8 is set, the data byte takes 4 serial-clock cycles and is sampled just before both edges of each cycle, most significant bit first.
- R6: Some reads get an error response with no chip-select activity. These are reads with offset not below the window length, reads while the engine is disabled, and reads while operation-word bit 23 (read flag) is clear.
- R7: A served read delivers its response exactly 2·N clock cycles after the accepting edge, where N = 8 + 8·A + dummy + (4 or 8). An error response appears one cycle after acceptance. A response stays valid with stable data until it is taken.
- R8: Writing control bit 31 as 0 while enabled and idle sets the stopped status one cycle after the write. Later reads get an error response.
- R9: A disable written during a read lets that read complete with correct data. The stopped status is set only in the cycle after the response is taken.
- R10: The stopped status is cleared by a status write with bit 11 set. A status write with bit 11 clear leaves it unchanged.
- R11: Control bits [22:21] choose which single chip select goes low for the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 operation word, 1 control, 2 base, 3 window length, 4 status |
| reg_wdata | input | 32 | Register write data |
| win_req_valid | input | 1 | Window read request |
| win_req_ready | output | 1 | Engine can accept a request |
| win_req_offset | input | OFF_W | Byte offset into the window |
| win_rsp_valid | output | 1 | Response available |
| win_rsp_ready | input | 1 | Response taken |
| win_rsp_data | output | 8 | Byte read from flash |
| win_rsp_err | output | 1 | Request was refused |
| lrd_off | output | 1 | Sticky stopped status |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | SLAVES | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Every result is due at a fixed cycle. A served response comes 2·N cycles after the accepting edge, an error response comes one cycle after it, and the stopped status comes one cycle after the engine becomes idle with a disable pending. The bench counts clock edges from the accepting edge and samples at falling clock edges. It requires the response to be absent for the first 2·N samples and present at the next one. A behavioural flash model counts serial-clock edges, captures opcode and address, and drives data bits from an address-derived pattern. Its counts and captures are compared with values the bench computes from the programmed settings.

// File: rtl/lrd_pkg.sv
// Shared register map, field positions and types of the window read engine.
// Assumes a 32-bit register write port and a fixed operation-word layout.
package lrd_pkg;
    localparam logic [2:0] REG_OPCFG = 3'd0;
    localparam logic [2:0] REG_CTRL  = 3'd1;
    localparam logic [2:0] REG_BASE  = 3'd2;
    localparam logic [2:0] REG_RANGE = 3'd3;
    localparam logic [2:0] REG_STAT  = 3'd4;

    localparam int CFG_READ_BIT  = 23;
    localparam int CFG_DUMMY_LSB = 17;
    localparam int CFG_ABYTE_LSB = 14;
    localparam int CFG_DDR_BIT   = 8;
    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_SLV_LSB  = 21;
    localparam int STAT_OFF_BIT  = 11;

    typedef struct packed {
        logic       rd;
        logic [5:0] dummy;
        logic [2:0] abytes;
        logic       ddr;
    } opcfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_RESP} seq_state_t;

    function automatic opcfg_t unpack_cfg(input logic [31:0] w);
        opcfg_t c;
        c.rd     = w[CFG_READ_BIT];
        c.dummy  = w[CFG_DUMMY_LSB +: 6];
        c.abytes = w[CFG_ABYTE_LSB +: 3];
        c.ddr    = w[CFG_DDR_BIT];
        return c;
    endfunction
endpackage

// File: rtl/lrd_regs.sv
// Register bank of the window read engine: operation word, control, base,
// window length and the sticky stopped status with its disable handshake.
// Assumes the sequencer reports idle whenever no read is accepted or pending.
module lrd_regs
    import lrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        seq_idle,
    output opcfg_t      cfg,
    output logic        en,
    output logic        pend,
    output logic [1:0]  slave,
    output logic [7:0]  opcode,
    output logic [31:0] base,
    output logic [31:0] range,
    output logic        off_sts
);
    logic unused_wbits;
    assign unused_wbits = ^wr_data;

    // Register writes, disable request tracking and quiesce completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            en      <= 1'b0;
            pend    <= 1'b0;
            slave   <= '0;
            opcode  <= '0;
            base    <= '0;
            range   <= '0;
            off_sts <= 1'b0;
        end else begin
            if (pend && seq_idle) begin
                en      <= 1'b0;
                pend    <= 1'b0;
                off_sts <= 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    REG_OPCFG: cfg   <= unpack_cfg(wr_data);
                    REG_BASE:  base  <= wr_data;
                    REG_RANGE: range <= wr_data;
                    REG_CTRL: begin
                        opcode <= wr_data[7:0];
                        slave  <= wr_data[CTRL_SLV_LSB +: 2];
                        if (wr_data[CTRL_EN_BIT]) begin
                            en   <= 1'b1;
                            pend <= 1'b0;
                        end else if (en) begin
                            pend <= 1'b1;
                        end
                    end
                    REG_STAT: if (wr_data[STAT_OFF_BIT]) off_sts <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // R8/R9: the stopped status only rises after a pending disable met an idle engine
    assert_off_after_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_sts) |-> $past(pend) && $past(seq_idle));
endmodule

// File: rtl/lrd_seq.sv
// Serial sequencer: accepts window reads, refuses invalid ones, and runs the
// opcode, address, dummy and data phases in clock mode 0 on a single line.
// Assumes one serial half-cycle per clock and settings stable at acceptance.
module lrd_seq
    import lrd_pkg::*;
#(
    parameter int SLAVES = 4,
    parameter int OFF_W  = 16,
    parameter int AMAX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  opcfg_t            cfg,
    input  logic              en,
    input  logic              pend,
    input  logic [1:0]        slave,
    input  logic [7:0]        opcode,
    input  logic [31:0]       base,
    input  logic [31:0]       range,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFF_W-1:0]  req_offset,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [7:0]        rsp_data,
    output logic              rsp_err,
    output logic              sclk,
    output logic [SLAVES-1:0] cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              idle
);
    localparam int ADDR_BITS = 8 * AMAX;
    localparam int SH_W      = 8 + ADDR_BITS;
    localparam int CNT_W     = $clog2(8 + ADDR_BITS + 64 + 8 + 1);

    seq_state_t           state;
    logic [SH_W-1:0]      shreg;
    logic [CNT_W-1:0]     cyc, last_q, dstart_q;
    logic                 half, ddr_q, err_q;
    logic [7:0]           rx_q;

    logic [2:0]           ab_eff;
    logic [ADDR_BITS-1:0] addr_sum, addr_al;
    logic [CNT_W-1:0]     pre_cnt, last_cnt;
    logic                 hit_ok;

    // Effective address length, aligned address and phase lengths for a new read.
    assign ab_eff   = (cfg.abytes > 3'(AMAX)) ? 3'(AMAX) : cfg.abytes;
    assign addr_sum = ADDR_BITS'(base + 32'(req_offset));
    assign addr_al  = addr_sum << (8 * (AMAX - int'(ab_eff)));
    assign pre_cnt  = CNT_W'(8 + 8 * int'(ab_eff) + int'(cfg.dummy));
    assign last_cnt = pre_cnt + (cfg.ddr ? CNT_W'(3) : CNT_W'(7));
    assign hit_ok   = en && !pend && cfg.rd && (32'(req_offset) < range);

    assign req_ready = (state == ST_IDLE) && !pend;
    assign rsp_valid = (state == ST_RESP);
    assign rsp_data  = rx_q;
    assign rsp_err   = err_q;
    assign mosi      = shreg[SH_W-1];
    assign idle      = (state == ST_IDLE);

    // Phase sequencing, serial clock generation and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cyc      <= '0;
            last_q   <= '0;
            dstart_q <= '0;
            half     <= 1'b0;
            ddr_q    <= 1'b0;
            err_q    <= 1'b0;
            rx_q     <= '0;
            sclk     <= 1'b0;
            cs_n     <= '1;
        end else begin
            case (state)
                ST_IDLE: if (req_valid && req_ready) begin
                    if (hit_ok) begin
                        shreg    <= {opcode, addr_al};
                        cyc      <= '0;
                        half     <= 1'b0;
                        last_q   <= last_cnt;
                        dstart_q <= pre_cnt;
                        ddr_q    <= cfg.ddr;
                        cs_n     <= ~(SLAVES'(1) << slave);
                        state    <= ST_SHIFT;
                    end else begin
                        err_q <= 1'b1;
                        rx_q  <= '0;
                        state <= ST_RESP;
                    end
                end
                ST_SHIFT: begin
                    if (!half) begin
                        sclk <= 1'b1;
                        half <= 1'b1;
                        if (cyc >= dstart_q) rx_q <= {rx_q[6:0], miso};
                    end else begin
                        sclk  <= 1'b0;
                        half  <= 1'b0;
                        shreg <= shreg << 1;
                        if (ddr_q && cyc >= dstart_q) rx_q <= {rx_q[6:0], miso};
                        if (cyc == last_q) begin
                            cs_n  <= '1;
                            err_q <= 1'b0;
                            state <= ST_RESP;
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: never more than one chip select active
    assert_cs_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R2: clock rests low whenever no device is selected
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);
    // R2: data line holds while the clock is high
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    // R7: a response is held with stable contents until taken
    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
endmodule

// File: rtl/linrd_engine.sv
// Top of the memory-mapped flash read window engine: register bank plus
// serial sequencer. Assumes all inputs are synchronous to clk.
module linrd_engine
    import lrd_pkg::*;
#(
    parameter int SLAVES = 4,
    parameter int OFF_W  = 16,
    parameter int AMAX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              win_req_valid,
    output logic              win_req_ready,
    input  logic [OFF_W-1:0]  win_req_offset,
    output logic              win_rsp_valid,
    input  logic              win_rsp_ready,
    output logic [7:0]        win_rsp_data,
    output logic              win_rsp_err,
    output logic              lrd_off,
    output logic              spi_sclk,
    output logic [SLAVES-1:0] spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    opcfg_t      cfg;
    logic        en, pend, seq_idle;
    logic [1:0]  slave;
    logic [7:0]  opcode;
    logic [31:0] base, range;

    lrd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .seq_idle(seq_idle), .cfg(cfg), .en(en),
        .pend(pend), .slave(slave), .opcode(opcode), .base(base),
        .range(range), .off_sts(lrd_off)
    );

    lrd_seq #(.SLAVES(SLAVES), .OFF_W(OFF_W), .AMAX(AMAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .en(en), .pend(pend),
        .slave(slave), .opcode(opcode), .base(base), .range(range),
        .req_valid(win_req_valid), .req_ready(win_req_ready),
        .req_offset(win_req_offset), .rsp_valid(win_rsp_valid),
        .rsp_ready(win_rsp_ready), .rsp_data(win_rsp_data),
        .rsp_err(win_rsp_err), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso), .idle(seq_idle)
    );
endmodule

// File: tb/sim_linrd_engine.sv
`timescale 1ns/1ps
module sim_linrd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        req_valid = 1'b0, req_ready;
    logic [15:0] req_off = '0;
    logic        rsp_valid, rsp_ready = 1'b1, rsp_err;
    logic [7:0]  rsp_data;
    logic        lrd_off, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;

    int nchk = 0, nerr = 0;

    // expected settings as programmed by the bench
    int b_base, b_range, b_op, b_slave, b_ab, b_dummy, b_ddr;

    // behavioural flash model state
    int          f_cnt = 0, f_done_cnt = 0, f_xfers = 0;
    bit          f_active = 0, f_mosi_bad = 0;
    logic        f_prev_sclk = 1'b0;
    logic [63:0] f_cap = '0;
    logic [7:0]  f_byte = '0;
    logic [3:0]  f_sel = '1;

    always #2.5 clk = ~clk;

    linrd_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .win_req_valid(req_valid), .win_req_ready(req_ready),
        .win_req_offset(req_off), .win_rsp_valid(rsp_valid), .win_rsp_ready(rsp_ready),
        .win_rsp_data(rsp_data), .win_rsp_err(rsp_err), .lrd_off(lrd_off),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
    endfunction

    function automatic logic [63:0] amask(input int ab);
        return (ab == 0) ? 64'd0 : ((64'd1 << (8 * ab)) - 64'd1);
    endfunction

    // flash model: counts clock edges, captures opcode/address, drives data
    always @(spi_sclk or spi_cs_n) begin
        int pre, k, j;
        pre = 8 + 8 * b_ab + b_dummy;
        if (spi_sclk !== f_prev_sclk) begin
            if (f_active && spi_sclk === 1'b1) begin
                f_cnt = f_cnt + 1;
                if (f_cnt <= 8 + 8 * b_ab) begin
                    f_cap = {f_cap[62:0], spi_mosi};
                    if (f_cnt == 8 + 8 * b_ab) f_byte = mem_byte(f_cap & amask(b_ab));
                end else if (spi_mosi !== 1'b0) f_mosi_bad = 1;
                j = f_cnt - 1 - pre;
                if (b_ddr != 0 && j >= 0 && j < 4) spi_miso = f_byte[6 - 2 * j];
            end else if (f_active && spi_sclk === 1'b0) begin
                k = f_cnt - pre;
                if (b_ddr == 0 && k >= 0 && k < 8) spi_miso = f_byte[7 - k];
                if (b_ddr != 0 && k >= 0 && k < 4) spi_miso = f_byte[7 - 2 * k];
            end
            f_prev_sclk = spi_sclk;
        end
        if (!f_active && spi_cs_n !== 4'hF) begin
            f_active = 1; f_cnt = 0; f_cap = '0; f_mosi_bad = 0;
            f_sel = spi_cs_n; f_xfers = f_xfers + 1;
        end else if (f_active && spi_cs_n === 4'hF) begin
            f_active = 0; f_done_cnt = f_cnt;
        end
    end

    task automatic check(input bit ok, input string msg, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic setup(input int op, input int slv, input int ab, input int dm,
                         input int ddr, input int base, input int rng, input bit rd);
        b_op = op; b_slave = slv; b_ab = (ab > 4) ? 4 : ab; b_dummy = dm; b_ddr = ddr;
        b_base = base; b_range = rng;
        reg_write(3'd0, (32'(rd) << 23) | (32'(dm) << 17) | (32'(ab) << 14) | (32'(ddr) << 8));
        reg_write(3'd2, base);
        reg_write(3'd3, rng);
        reg_write(3'd1, 32'h8000_0000 | (32'(slv) << 21) | 32'(op));
    endtask

    // one window read with cycle-exact response timing checks
    task automatic do_read(input int off, input bit exp_err, input string tag, input int hold);
        int n, xf0;
        bit early;
        logic [63:0] ea;
        logic [7:0] d0;
        xf0 = f_xfers;
        @(negedge clk); req_valid = 1'b1; req_off = 16'(off);
        if (hold > 0) rsp_ready = 1'b0;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        if (exp_err) begin
            check(rsp_valid === 1'b1 && rsp_err === 1'b1, {tag, " error response one cycle after accept"},
                  {rsp_valid, rsp_err}, 2'b11);
            check(f_xfers == xf0 && spi_cs_n === 4'hF, {tag, " no flash access on refused read"},
                  f_xfers - xf0, 0);
        end else begin
            n = 8 + 8 * b_ab + b_dummy + (b_ddr != 0 ? 4 : 8);
            early = rsp_valid;
            for (int i = 1; i < 2 * n; i++) begin
                @(negedge clk);
                if (rsp_valid) early = 1;
            end
            @(negedge clk);
            ea = (64'(b_base) + 64'(off)) & amask(b_ab);
            check(!early && rsp_valid === 1'b1 && rsp_err === 1'b0,
                  {tag, " R7 response exactly 2N cycles after accept"}, {early, rsp_valid, rsp_err}, 3'b010);
            check(rsp_data === mem_byte(ea), {tag, " data byte"}, rsp_data, mem_byte(ea));
            check(64'(f_cap >> (8 * b_ab)) == 64'(b_op) && (f_cap & amask(b_ab)) == ea,
                  {tag, " R2 opcode and address"}, f_cap, (64'(b_op) << (8 * b_ab)) | ea);
            check(f_done_cnt == n && !f_mosi_bad, {tag, " clock cycle count and low data line"},
                  f_done_cnt, n);
            check(f_sel === ~(4'd1 << b_slave), {tag, " R11 selected device"}, f_sel, ~(4'd1 << b_slave));
        end
        if (hold > 0) begin
            d0 = rsp_data;
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(rsp_valid === 1'b1 && rsp_data === d0, {tag, " R7 response held until taken"},
                      rsp_data, d0);
            end
            rsp_ready = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R7 watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        b_base = 0; b_range = 0; b_op = 0; b_slave = 0; b_ab = 0; b_dummy = 0; b_ddr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n === 4'hF && spi_sclk === 1'b0 && rsp_valid === 1'b0 && lrd_off === 1'b0
              && req_ready === 1'b1, "R1 reset state", {spi_cs_n, spi_sclk, rsp_valid, lrd_off}, 7'h78);

        do_read(0, 1, "R6 disabled", 0);

        setup(8'h03, 0, 3, 0, 0, 32'h0000_1000, 16, 1);
        do_read(5, 0, "R4 sdr 3-byte", 0);
        do_read(16, 1, "R6 offset at length", 0);
        do_read(15, 0, "R6 last in-range offset", 0);

        setup(8'h0B, 2, 4, 8, 0, 32'h1234_5678, 32'h100, 1);
        do_read(32'h20, 0, "R3 dummy cycles slave 2", 0);

        setup(8'h13, 3, 6, 0, 0, 32'hA5C3_0F11, 32'h100, 1);
        do_read(3, 0, "R2 address count clamped", 0);

        setup(8'hEE, 1, 3, 4, 1, 32'h0004_2000, 64, 1);
        do_read(7, 0, "R5 double rate", 3);
        do_read(40, 0, "R5 double rate second", 0);

        setup(8'h03, 0, 3, 0, 0, 32'h0000_1000, 16, 0);
        do_read(1, 1, "R6 read flag clear", 0);

        setup(8'h03, 1, 2, 2, 0, 32'h0000_3300, 16, 1);
        reg_write(3'd1, 32'h0000_0003);
        check(lrd_off === 1'b0, "R8 status not set before quiesce", lrd_off, 0);
        @(negedge clk);
        check(lrd_off === 1'b1 && spi_cs_n === 4'hF, "R8 status one cycle after disable", lrd_off, 1);
        do_read(2, 1, "R8 read after disable", 0);

        reg_write(3'd4, 32'h0000_0000);
        check(lrd_off === 1'b1, "R10 write without bit 11 keeps status", lrd_off, 1);
        reg_write(3'd4, 32'h0000_0800);
        check(lrd_off === 1'b0, "R10 write-one-to-clear", lrd_off, 0);

        setup(8'h03, 1, 2, 2, 0, 32'h0000_3300, 16, 1);
        fork
            do_read(9, 0, "R9 read during disable", 0);
            begin
                repeat (20) @(negedge clk);
                reg_write(3'd1, 32'h0020_0003);
            end
        join
        check(lrd_off === 1'b0, "R9 status held while response pending", lrd_off, 0);
        @(negedge clk);
        check(lrd_off === 1'b0, "R9 status not set in handshake cycle", lrd_off, 0);
        @(negedge clk);
        check(lrd_off === 1'b1 && spi_cs_n === 4'hF, "R9 status after quiesce", lrd_off, 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule